// File: doc/BRIEF.md
# E1 Resync Criteria Monitor

This block sits beside an E1 receive framer and decides when an alignment level has degraded far enough that a resync must be forced. The framer's word checkers report each received frame alignment word, each CAS multiframe alignment word and each CRC-4 codeword. Each report is a one-cycle strobe with an error flag. Three independent detectors apply their own loss criterion:

- The frame alignment detector fires on three consecutive errored words.
- The CAS multiframe detector fires on two consecutive errored words.
- The CRC-4 detector fires when 915 codeword errors build up inside a fixed block of 1000 codewords.

Each firing sets a sticky event bit. Software or a supervisor reads the event bits through a small read port, and reading them clears them. The same port also returns three real-time flags that the synchronizer drives while each alignment search is running. During a CRC-level resync the synchronizer re-checks frame alignment. If it briefly locks onto a pattern that imitates the alignment word, the frame-level event can also appear. The monitor simply reports what it is given.

The run detectors are two-state machines:

- **CLEAN** means no error run is in progress.
  - It moves to **ERRING** on an errored word.
- **ERRING** means a run has started.
  - It returns to CLEAN on a good word.
  - It also returns to CLEAN when the run reaches its length, where it fires and restarts its count.
  - It stays in ERRING on further errored words below that length.

The CRC window detector also has two states:

- **OPEN** means the block threshold has not yet been reached.
  - It moves to **TRIPPED** on the codeword that brings the error count to 915, which is where it fires.
- **TRIPPED** means the block has already fired.
  - It returns to OPEN when the 1000th codeword of the block clears both counters.
  - The clearing codeword can be the firing one, in which case the detector fires and goes back to OPEN in the same cycle.

Top module: `e1rs_monitor`

## Requirements
- R1: After reset, every read returns 0 until an event is latched.
- R2: After three consecutive frame alignment strobes with the error flag set, event bit 1 is set. The run count then restarts, so a sixth consecutive error fires again.
- R3: After two consecutive CAS multiframe strobes with the error flag set, event bit 0 is set.
- R4: A strobe with the error flag clear resets the run of its own word type only. An error flag without its strobe, or a strobe of another word type, neither extends nor breaks a run.
- R5: Event bit 2 is set on the CRC-4 codeword that makes the error count in the current block equal 915. It is not set at 914.
- R6: After every 1000th CRC-4 codeword both the codeword count and the error count restart from zero. Errors from one block never count toward the next.
- R7: A read at address 0 returns the event bits {bits 7:3 = 0, bit 2 CRC, bit 1 frame, bit 0 CAS} as they were before the read. The bits are then cleared.
- R8: An event that is detected in the same cycle as an address-0 read stays set after the read.
- R9: A read at address 1 returns {bits 7:3 = 0, bit 2 frame search, bit 1 CAS search, bit 0 CRC-4 search}. It leaves the event bits untouched.
- R10: A read at any other address returns 0. When no read is requested, the read data holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fas_stb | input | 1 | Frame alignment word received |
| fas_err | input | 1 | That word was in error |
| cas_stb | input | 1 | CAS multiframe word received |
| cas_err | input | 1 | That word was in error |
| crc_stb | input | 1 | CRC-4 codeword checked |
| crc_err | input | 1 | That codeword was in error |
| fas_srch | input | 1 | Frame alignment search running |
| cas_srch | input | 1 | CAS multiframe search running |
| crc_srch | input | 1 | CRC-4 multiframe search running |
| rd_en | input | 1 | Read request |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data, valid one cycle after rd_en |

## Verification
A word strobe sampled at one clock edge latches its event at that same edge, so a read issued in the very next cycle already sees it. Read data appears one clock edge after rd_en is sampled. The bench drives inputs at the falling edge, updates its model just after the rising edge and compares rd_data at the following falling edge. That is exactly one register stage after the request. Same-cycle read-and-event cases (R8) are checked over two consecutive reads, so both the old value and the surviving bit are observed.

// File: rtl/e1rs_pkg.sv
`timescale 1ns/1ps
package e1rs_pkg;
    typedef enum logic {RUN_CLEAN, RUN_ERRING} run_state_t;
    typedef enum logic {WIN_OPEN, WIN_TRIPPED} win_state_t;
    localparam int EV_CAS = 0;
    localparam int EV_FAS = 1;
    localparam int EV_CRC = 2;
    localparam int NUM_EV = 3;
endpackage

// File: rtl/e1rs_run_det.sv
`timescale 1ns/1ps
module e1rs_run_det
    import e1rs_pkg::*;
#(
    parameter int RUN_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stb,
    input  logic err,
    output logic fire
);
    localparam int CW = $clog2(RUN_LEN + 1);
    localparam logic [CW-1:0] LAST = CW'(RUN_LEN - 1);

    run_state_t st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= RUN_CLEAN;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        fire  = 1'b0;
        unique case (st_q)
            RUN_CLEAN: begin
                if (stb && err) begin
                    if (cnt_q == LAST) begin
                        fire  = 1'b1;
                        cnt_d = '0;
                    end else begin
                        st_d  = RUN_ERRING;
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            RUN_ERRING: begin
                if (stb && !err) begin
                    st_d  = RUN_CLEAN;
                    cnt_d = '0;
                end else if (stb && err) begin
                    if (cnt_q == LAST) begin
                        fire  = 1'b1;
                        st_d  = RUN_CLEAN;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            default: begin
                st_d  = RUN_CLEAN;
                cnt_d = '0;
            end
        endcase
    end

    // R2
    run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(RUN_LEN));
    // R4
    good_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && !err) |=> (cnt_q == '0 && st_q == RUN_CLEAN));
    // R4
    idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stb |=> $stable(cnt_q));
endmodule

// File: rtl/e1rs_crc_win.sv
`timescale 1ns/1ps
module e1rs_crc_win
    import e1rs_pkg::*;
#(
    parameter int BLOCK  = 1000,
    parameter int THRESH = 915
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stb,
    input  logic err,
    output logic fire
);
    localparam int CW = $clog2(BLOCK + 1);
    localparam logic [CW-1:0] LAST_W = CW'(BLOCK - 1);
    localparam logic [CW-1:0] PRE_T  = CW'(THRESH - 1);

    win_state_t st_q, st_d;
    logic [CW-1:0] wcnt_q, wcnt_d, ecnt_q, ecnt_d;
    logic blk_end;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= WIN_OPEN;
            wcnt_q <= '0;
            ecnt_q <= '0;
        end else begin
            st_q   <= st_d;
            wcnt_q <= wcnt_d;
            ecnt_q <= ecnt_d;
        end
    end

    always_comb begin
        blk_end = stb && (wcnt_q == LAST_W);
        wcnt_d  = wcnt_q;
        ecnt_d  = ecnt_q;
        if (stb) begin
            wcnt_d = blk_end ? '0 : wcnt_q + 1'b1;
            ecnt_d = blk_end ? '0 : ecnt_q + CW'(err);
        end
    end

    always_comb begin
        st_d = st_q;
        fire = 1'b0;
        unique case (st_q)
            WIN_OPEN: begin
                if (stb && err && ecnt_q == PRE_T) begin
                    fire = 1'b1;
                    st_d = blk_end ? WIN_OPEN : WIN_TRIPPED;
                end
            end
            WIN_TRIPPED: begin
                if (blk_end) st_d = WIN_OPEN;
            end
            default: st_d = WIN_OPEN;
        endcase
    end

    // R6
    blk_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && wcnt_q == LAST_W) |=> (wcnt_q == '0 && ecnt_q == '0));
    // R5
    err_le_words_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ecnt_q <= wcnt_q);
    // R5
    tripped_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == WIN_TRIPPED) |-> (ecnt_q >= CW'(THRESH)));
endmodule

// File: rtl/e1rs_regs.sv
`timescale 1ns/1ps
module e1rs_regs
    import e1rs_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_EV-1:0] ev,
    input  logic [2:0]        srch,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam logic [ADDR_W-1:0] A_EVT  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(1);

    logic [NUM_EV-1:0] evt_q;
    logic              clr;

    assign clr = rd_en && (rd_addr == A_EVT);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_q   <= '0;
            rd_data <= '0;
        end else begin
            evt_q <= clr ? ev : (evt_q | ev);
            if (rd_en) begin
                if (rd_addr == A_EVT)       rd_data <= DATA_W'(evt_q);
                else if (rd_addr == A_STAT) rd_data <= DATA_W'(srch);
                else                        rd_data <= '0;
            end
        end
    end

    // R8
    ev_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && ev[EV_FAS]) |=> evt_q[EV_FAS]);
    // R7
    rd_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && ev == '0) |=> evt_q == '0);
    // R7
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[DATA_W-1:NUM_EV] == '0);
    // R9
    stat_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == A_STAT) |=> ((evt_q & $past(evt_q)) == $past(evt_q)));
endmodule

// File: rtl/e1rs_monitor.sv
`timescale 1ns/1ps
module e1rs_monitor
    import e1rs_pkg::*;
#(
    parameter int FAS_RUN   = 3,
    parameter int CAS_RUN   = 2,
    parameter int CRC_BLOCK = 1000,
    parameter int CRC_LIMIT = 915,
    parameter int ADDR_W    = 2,
    parameter int DATA_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fas_stb,
    input  logic              fas_err,
    input  logic              cas_stb,
    input  logic              cas_err,
    input  logic              crc_stb,
    input  logic              crc_err,
    input  logic              fas_srch,
    input  logic              cas_srch,
    input  logic              crc_srch,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic [NUM_EV-1:0] ev;

    e1rs_run_det #(.RUN_LEN(FAS_RUN)) u_fas_det (
        .clk(clk), .rst_n(rst_n), .stb(fas_stb), .err(fas_err), .fire(ev[EV_FAS])
    );

    e1rs_run_det #(.RUN_LEN(CAS_RUN)) u_cas_det (
        .clk(clk), .rst_n(rst_n), .stb(cas_stb), .err(cas_err), .fire(ev[EV_CAS])
    );

    e1rs_crc_win #(.BLOCK(CRC_BLOCK), .THRESH(CRC_LIMIT)) u_crc_win (
        .clk(clk), .rst_n(rst_n), .stb(crc_stb), .err(crc_err), .fire(ev[EV_CRC])
    );

    e1rs_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .ev(ev),
        .srch({fas_srch, cas_srch, crc_srch}),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        !rst_n |=> rd_data == '0);
    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
endmodule

// File: tb/e1rs_monitor_bench.sv
`timescale 1ns/1ps
module e1rs_monitor_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fas_stb = 0, fas_err = 0, cas_stb = 0, cas_err = 0, crc_stb = 0, crc_err = 0;
    logic fas_srch = 0, cas_srch = 0, crc_srch = 0;
    logic rd_en = 0;
    logic [1:0] rd_addr = 0;
    logic [7:0] rd_data;

    int n_chk = 0, n_bad = 0;
    int m_rf = 0, m_rc = 0, m_kw = 0, m_ke = 0;
    logic [2:0] m_ev = 0;
    logic [7:0] m_rd = 0;

    always #2.5 clk = ~clk;

    e1rs_monitor u_e1rs_monitor (
        .clk(clk), .rst_n(rst_n),
        .fas_stb(fas_stb), .fas_err(fas_err), .cas_stb(cas_stb), .cas_err(cas_err),
        .crc_stb(crc_stb), .crc_err(crc_err),
        .fas_srch(fas_srch), .cas_srch(cas_srch), .crc_srch(crc_srch),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: rd_data=%02h expected=%02h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model of one clock edge, from the requirements.
    function automatic logic [2:0] model_step();
        logic [2:0] nev = 0;
        if (fas_stb) begin
            if (fas_err) begin
                if (m_rf + 1 == 3) begin nev[1] = 1; m_rf = 0; end else m_rf++;
            end else m_rf = 0;
        end
        if (cas_stb) begin
            if (cas_err) begin
                if (m_rc + 1 == 2) begin nev[0] = 1; m_rc = 0; end else m_rc++;
            end else m_rc = 0;
        end
        if (crc_stb) begin
            int e = m_ke + (crc_err ? 1 : 0);
            if (crc_err && e == 915) nev[2] = 1;
            if (m_kw + 1 == 1000) begin m_kw = 0; m_ke = 0; end
            else begin m_kw++; m_ke = e; end
        end
        return nev;
    endfunction

    // Called at a falling edge with inputs set; returns at the next falling edge.
    task automatic cyc(string tag);
        logic [2:0] nev;
        @(posedge clk);
        #0.5;
        nev = model_step();
        if (rd_en) begin
            if (rd_addr == 0) begin m_rd = {5'b0, m_ev}; m_ev = nev; end
            else begin
                m_rd = (rd_addr == 1) ? {5'b0, fas_srch, cas_srch, crc_srch} : 8'h00;
                m_ev = m_ev | nev;
            end
        end else m_ev = m_ev | nev;
        @(negedge clk);
        chk(tag, rd_data, m_rd);
        {fas_stb, fas_err, cas_stb, cas_err, crc_stb, crc_err, rd_en} = '0;
    endtask

    task automatic word(int kind, logic e, string tag);
        case (kind)
            0: begin fas_stb = 1; fas_err = e; end
            1: begin cas_stb = 1; cas_err = e; end
            default: begin crc_stb = 1; crc_err = e; end
        endcase
        cyc(tag);
    endtask

    task automatic rd(logic [1:0] a, logic [7:0] exp, string tag);
        rd_en = 1; rd_addr = a;
        cyc(tag);
        chk(tag, rd_data, exp);
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_bad++;
        $display("FAIL watchdog: rd_data=%02h expected=done", rd_data);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        chk("R1 reset", rd_data, 8'h00);
        rd(0, 8'h00, "R1 first read");

        // R2: three frame errors, and a second run of three
        repeat (3) word(0, 1, "R2");
        rd(0, 8'h02, "R2 fas event");
        repeat (2) word(0, 1, "R2");
        rd(0, 8'h00, "R2 two errors only");
        word(0, 1, "R2");
        rd(0, 8'h02, "R2 restart fires again");

        // R3
        repeat (2) word(1, 1, "R3");
        rd(0, 8'h01, "R3 cas event");

        // R4: good word breaks the run; other types and bare flags do not
        repeat (2) word(0, 1, "R4");
        word(0, 0, "R4");
        repeat (2) word(0, 1, "R4");
        rd(0, 8'h00, "R4 good word clears run");
        word(1, 1, "R4");
        word(0, 0, "R4");
        cas_err = 1; cyc("R4");
        word(2, 0, "R4");
        word(1, 1, "R4");
        rd(0, 8'h01, "R4 other strobes ignored");
        m_kw = m_kw; // model already tracked the one CRC codeword

        // R5 / R6: finish the current CRC block first (one good codeword was sent)
        repeat (999) word(2, 0, "R6");
        repeat (914) word(2, 1, "R5");
        rd(0, 8'h00, "R5 at 914");
        word(2, 1, "R5");
        rd(0, 8'h04, "R5 at 915");
        repeat (85) word(2, 0, "R6");
        repeat (914) word(2, 1, "R6");
        repeat (86) word(2, 0, "R6");
        word(2, 1, "R6");
        rd(0, 8'h00, "R6 no carry across block");

        // R8: read coincides with third frame error
        repeat (2) word(0, 1, "R8");
        fas_stb = 1; fas_err = 1; rd_en = 1; rd_addr = 0;
        cyc("R8");
        chk("R8 old value", rd_data, 8'h00);
        rd(0, 8'h02, "R8 event survives read");

        // R9 / R10
        fas_srch = 1; cas_srch = 0; crc_srch = 1;
        repeat (2) word(1, 1, "R9");
        rd(1, 8'h05, "R9 status");
        rd(0, 8'h01, "R9 events untouched");
        rd(2, 8'h00, "R10 addr 2");
        rd(3, 8'h00, "R10 addr 3");
        fas_srch = 0; crc_srch = 0; cas_srch = 1;
        rd(1, 8'h02, "R9 cas search");
        repeat (3) cyc("R10 hold");
        chk("R10 hold", rd_data, 8'h02);

        // Constrained random mix
        void'($urandom(32'h1e1));
        for (int i = 0; i < 6000; i++) begin
            fas_stb = ($urandom % 4) == 0; fas_err = ($urandom % 3) != 0;
            cas_stb = ($urandom % 6) == 0; cas_err = ($urandom % 2) != 0;
            crc_stb = ($urandom % 2) == 0; crc_err = ($urandom % 100) < 95;
            {fas_srch, cas_srch, crc_srch} = 3'($urandom);
            rd_en = ($urandom % 10) == 0; rd_addr = 2'($urandom);
            cyc("R7 R9 random");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule